// File: doc/BRIEF.md
# Segmented Tapped Serial Shift Register

This block is a 64-stage serial shift register built from four 16-stage segments, with a tap after the last stage of each segment. It shifts on every rising clock edge and has no way to hold. In chain mode, with write enable low, the segments link end to end into one 64-stage delay line. The four taps show the bits that are 16, 32, 48 and 64 clocks old, and all four tap output enables are asserted.

When write enable is high, every tap output enable is withdrawn. The three inner tap lines then act as inputs: each one feeds the first stage of the segment that follows it. The main data input still feeds the first segment. All four segments therefore fill in parallel, and a full 64-bit pattern loads in 16 clocks. Dropping write enable afterwards restores the single chain, so the loaded pattern can be shifted out of the last tap.

The block does not use a valid/ready handshake, because it has nothing to stall. Every clock consumes one bit per active input and advances every stage, so back-pressure does not apply. Two independent copies make a dual register. Segment length and segment count are parameters.

Top module: `seg_shift_reg`

## Requirements
- R1: A synchronous active-high reset clears all stages to zero, so every tap output reads 0 after reset.
- R2: With write enable low, a bit applied to the data input before rising edge 1 first appears on tap_out[k] after rising edge 16*(k+1), and on no tap at any other edge count.
- R3: With write enable low, the tap_in lines have no effect on any stage.
- R4: The data input is shifted into the first stage of segment 0 on every rising edge, whatever the level of write enable.
- R5: With write enable high, tap_in[k] is shifted into the first stage of segment k+1 on each rising edge.
- R6: With write enable high for 16 clocks, with data input = P[48+j], tap_in[0] = P[32+j], tap_in[1] = P[16+j] and tap_in[2] = P[j] driven at load clock j, followed by write enable low, tap_out[3] presents P[i] before readout edge i, for i = 0..63.
- R7: Every bit of tap_oe equals the inverse of write enable, with no clock delay.
- R8: tap_out[k] always shows the last stage of segment k, including while its output enable is withdrawn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | High: parallel segment load, outputs disabled |
| din | input | 1 | Serial data into segment 0 |
| tap_in | input | NUM_SEG-1 | Serial data into segments 1..NUM_SEG-1 during load |
| tap_out | output | NUM_SEG | Last stage of each segment |
| tap_oe | output | NUM_SEG | Output enable per tap, high in chain mode |

## Verification
The bench builds the block with SEG_LEN = 16 and NUM_SEG = 4. This puts the real 16/32/48/64 latencies and the 16-clock parallel load within reach. A single pulse walking the whole chain exposes any off-by-one in segment length, and any tap that fires early or late. Loading four distinct 64-bit patterns and reading them back serially checks the segment ordering and the choice of segment inputs in both modes.

// File: rtl/seg_sr_pkg.sv
package seg_sr_pkg;

  typedef enum logic {
    MODE_CHAIN = 1'b0,
    MODE_LOAD  = 1'b1
  } sr_mode_e;

endpackage

// File: rtl/seg_sr_ctl.sv
module seg_sr_ctl
  import seg_sr_pkg::*;
#(
  parameter int NUM_SEG = 4
) (
  input  logic               wr_en,
  output sr_mode_e           mode,
  output logic [NUM_SEG-1:0] oe
);

  always_comb begin
    mode = wr_en ? MODE_LOAD : MODE_CHAIN;
  end

  // Enables are released whenever the segments are being loaded.
  always_comb begin
    oe = (mode == MODE_LOAD) ? '0 : '1;
  end

endmodule

// File: rtl/seg_sr_segment.sv
module seg_sr_segment #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_in,
  output logic head,
  output logic tail
);

  localparam int TOP = LEN - 1;

  logic [TOP:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg <= {stg[TOP-1:0], ser_in};
    end
  end

  assign head = stg[0];
  assign tail = stg[TOP];

endmodule

// File: rtl/seg_shift_reg.sv
module seg_shift_reg
  import seg_sr_pkg::*;
#(
  parameter int SEG_LEN = 16,
  parameter int NUM_SEG = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               din,
  input  logic [NUM_SEG-2:0] tap_in,
  output logic [NUM_SEG-1:0] tap_out,
  output logic [NUM_SEG-1:0] tap_oe
);

  sr_mode_e           mode;
  logic [NUM_SEG-1:0] seg_in;
  logic [NUM_SEG-1:0] seg_head;
  logic [NUM_SEG-1:0] seg_tail;

  seg_sr_ctl #(
    .NUM_SEG(NUM_SEG)
  ) u_ctl (
    .wr_en(wr_en),
    .mode (mode),
    .oe   (tap_oe)
  );

  assign seg_in[0] = din;

  genvar k;
  generate
    for (k = 0; k < NUM_SEG; k++) begin : g_seg
      if (k > 0) begin : g_sel
        assign seg_in[k] = (mode == MODE_LOAD) ? tap_in[k-1] : seg_tail[k-1];

        // R5
        load_head_chk: assert property (@(posedge clk) disable iff (rst)
          wr_en |=> seg_head[k] == $past(tap_in[k-1]));

        // R2
        chain_head_chk: assert property (@(posedge clk) disable iff (rst)
          !wr_en |=> seg_head[k] == $past(seg_tail[k-1]));
      end

      seg_sr_segment #(
        .LEN(SEG_LEN)
      ) u_seg (
        .clk   (clk),
        .rst   (rst),
        .ser_in(seg_in[k]),
        .head  (seg_head[k]),
        .tail  (seg_tail[k])
      );
    end
  endgenerate

  assign tap_out = seg_tail;

  // R4
  din_head_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> seg_head[0] == $past(din));

  // R7
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> tap_oe == '0);

  // R7
  oe_on_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> &tap_oe);

endmodule

// File: tb/seg_shift_reg_tb.sv
module seg_shift_reg_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SEG_LEN    = 16;
  localparam int NUM_SEG    = 4;
  localparam int TOTAL      = SEG_LEN * NUM_SEG;
  localparam int NPAT       = 4;

  localparam logic [TOTAL-1:0] PATS [NPAT] = '{
    64'hDEAD_BEEF_0123_4567,
    64'h8000_0000_0000_0001,
    64'hFFFF_0000_AAAA_5555,
    64'h0F0F_F0F0_3C3C_C3C3
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               wr_en = 1'b0;
  logic               din = 1'b0;
  logic [NUM_SEG-2:0] tap_in = '0;
  logic [NUM_SEG-1:0] tap_out;
  logic [NUM_SEG-1:0] tap_oe;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_shift_reg #(
    .SEG_LEN(SEG_LEN),
    .NUM_SEG(NUM_SEG)
  ) u_dut (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .din    (din),
    .tap_in (tap_in),
    .tap_out(tap_out),
    .tap_oe (tap_oe)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 taps after reset", 64'(tap_out), 64'h0);
    check("R7 oe in chain mode", 64'(tap_oe), 64'hF);

    // Table walk: parallel load then serial readout
    for (int p = 0; p < NPAT; p++) begin
      wr_en = 1'b1;
      #1;
      check("R7 oe during load", 64'(tap_oe), 64'h0);
      for (int j = 0; j < SEG_LEN; j++) begin
        din = PATS[p][(NUM_SEG-1)*SEG_LEN + j];
        for (int k = 1; k < NUM_SEG; k++)
          tap_in[k-1] = PATS[p][(NUM_SEG-1-k)*SEG_LEN + j];
        @(negedge clk);
      end
      // R8: taps visible while disabled; R4/R5 first-loaded bit at each tail
      for (int k = 0; k < NUM_SEG; k++)
        check("R8 R5 R4 tap after load", 64'(tap_out[k]),
              64'(PATS[p][(NUM_SEG-1-k)*SEG_LEN]));
      wr_en = 1'b0;
      din = 1'b0;
      tap_in = '0;
      #1;
      check("R7 oe after load", 64'(tap_oe), 64'hF);
      for (int i = 0; i < TOTAL; i++) begin
        check("R6 readout bit", 64'(tap_out[NUM_SEG-1]), 64'(PATS[p][i]));
        @(negedge clk);
      end
      check("R2 drained", 64'(tap_out), 64'h0);
    end

    // R2/R3: single pulse latency with noisy tap_in
    din = 1'b1;
    @(negedge clk);
    din = 1'b0;
    for (int c = 1; c <= TOTAL + 4; c++) begin
      logic [NUM_SEG-1:0] exp_t;
      for (int k = 0; k < NUM_SEG; k++)
        exp_t[k] = (c == SEG_LEN * (k + 1));
      check("R2 R3 pulse latency", 64'(tap_out), 64'(exp_t));
      tap_in = NUM_SEG'(c) ^ '1;
      @(negedge clk);
    end
    tap_in = '0;

    // R1: reset mid-run clears loaded content
    wr_en = 1'b1;
    din = 1'b1;
    tap_in = '1;
    repeat (SEG_LEN) @(negedge clk);
    check("R5 all ones loaded", 64'(tap_out), 64'hF);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    wr_en = 1'b0;
    din = 1'b0;
    tap_in = '0;
    check("R1 mid-run reset", 64'(tap_out), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule